// File: doc/BRIEF.md
# Rectangle Fill and Vertical Copy Raster Engine

This block is a small 2D raster engine for a frame buffer of 32-bit pixels. Software programs a handful of registers through a one-cycle write port: an opcode, a source corner, a destination corner, a box height, a foreground colour, a raster-op code and a plane mask. The width register is written last, and that write launches the command. While the command runs, the engine issues one request per cycle to a synchronous frame memory port. It either paints the box with the foreground colour or copies a box of rows from the source corner to the destination corner.

Every pixel write is a read-modify-write. The engine first reads the destination pixel. It then applies the raster-op to the new value (the foreground colour, or the source pixel) and the old value. Finally it merges the result with the old pixel under the plane mask. Rows are 2048 pixels apart (an 8192-byte pitch), whatever the visible resolution. The colour word carries red in bits 7:0, green in 15:8 and blue in 23:16. The engine passes it through unchanged.

Top module: `rbe_box_engine`

## Requirements
- R1: After reset, busy_o and mem_req_o are low. The raster-op register holds 0x83, the plane mask is all ones, and every other register is zero.
- R2: Writes at reg_addr_i go to these registers: 0 opcode, 1 source row, 2 source column, 3 destination row, 4 destination column, 5 height, 7 foreground, 8 raster-op, 9 plane mask. A write to 6 sets the width and launches the command if the opcode is 0x08 or 0x0B. Any other opcode produces no memory access and leaves busy_o low.
- R3: Opcode 0x08 writes the foreground colour to every pixel of the height-by-width box whose top-left corner is at the destination row and column. The pixel address on mem_addr_o is {row, column}, which equals row*2048+column, with the row and the column each wrapping modulo 2048.
- R4: Opcode 0x0B reads the box whose corner is at the source row and column, and writes each of its pixels to the same offset from the destination corner.
- R5: For each written pixel, raster-op 0x83 yields the new value, 0x85 the old destination value, and 0x86 new XOR old. Any other code yields the new value.
- R6: A written pixel takes the raster-op result in the bits where the plane mask is 1, and keeps the old destination bits where the mask is 0.
- R7: A copy whose destination row is greater than its source row walks rows from the bottom of the box to the top. Every other copy walks from the top to the bottom. Columns always ascend. As a result, overlapping copies give the same result as copying one pixel at a time in that order.
- R8: A launch with zero height or zero width makes no memory access and leaves busy_o low.
- R9: Register writes made while busy_o is high are ignored, and this includes a write to the width register.
- R10: busy_o rises on the clock edge that takes the launching write. It falls on the edge right after the last pixel write is issued. mem_req_o is never high while busy_o is low.
- R11: A fill takes exactly 2 cycles per pixel (read the destination, then write it). A copy takes exactly 3 cycles per pixel (read the source, read the destination, then write). Two writes never occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select |
| reg_wdata_i | input | DATA_W | Register write data |
| busy_o | output | 1 | Command in progress |
| mem_req_o | output | 1 | Frame memory request |
| mem_we_o | output | 1 | Request is a write (else a read) |
| mem_addr_o | output | Y_W+X_W | Pixel address {row, column} |
| mem_wdata_o | output | DATA_W | Pixel write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read request and held until the next read |

## Verification
The plane-mask assertion assumes that the frame memory returns read data one cycle after a read request and holds it until the next read. Under that assumption, mem_rdata_i during a write cycle is the destination pixel that was just fetched. The bench memory model follows exactly that protocol. The bench also keeps every box small enough that the height and width fit their fields. Random boxes sit near row zero and sometimes straddle the column wrap at 2047, so the rows never wrap.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  localparam logic [7:0] OP_FILL   = 8'h08;
  localparam logic [7:0] OP_SCROLL = 8'h0B;

  localparam logic [7:0] ROP_NEW = 8'h83;
  localparam logic [7:0] ROP_OLD = 8'h85;
  localparam logic [7:0] ROP_XOR = 8'h86;

  localparam logic [3:0] RA_OP     = 4'd0;
  localparam logic [3:0] RA_SRC_Y  = 4'd1;
  localparam logic [3:0] RA_SRC_X  = 4'd2;
  localparam logic [3:0] RA_DST_Y  = 4'd3;
  localparam logic [3:0] RA_DST_X  = 4'd4;
  localparam logic [3:0] RA_HEIGHT = 4'd5;
  localparam logic [3:0] RA_WIDTH  = 4'd6;
  localparam logic [3:0] RA_FG     = 4'd7;
  localparam logic [3:0] RA_ROP    = 4'd8;
  localparam logic [3:0] RA_PMASK  = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WRITE
  } eng_state_e;
endpackage

// File: rtl/rbe_pixel_alu.sv
module rbe_pixel_alu
  import rbe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [7:0]        rop_i,
  input  logic [DATA_W-1:0] pmask_i,
  output logic [DATA_W-1:0] pix_o
);
  logic [DATA_W-1:0] rop_res;

  always_comb begin
    unique case (rop_i)
      ROP_OLD: rop_res = old_i;
      ROP_XOR: rop_res = new_i ^ old_i;
      default: rop_res = new_i;
    endcase
    pix_o = (rop_res & pmask_i) | (old_i & ~pmask_i);
  end
endmodule

// File: rtl/rbe_walker.sv
module rbe_walker #(
  parameter int X_W = 11,
  parameter int Y_W = 11,
  localparam int ADDR_W = X_W + Y_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              copy_i,
  input  logic [Y_W-1:0]    by_i,
  input  logic [X_W-1:0]    bx_i,
  input  logic [Y_W-1:0]    dy_i,
  input  logic [X_W-1:0]    dx_i,
  input  logic [Y_W-1:0]    h_i,
  input  logic [X_W-1:0]    w_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              last_o
);
  logic [Y_W-1:0] row_q, rows_done_q;
  logic [X_W-1:0] col_q;
  logic           rev_q;
  logic           rev_d;
  logic           row_end;
  logic [Y_W-1:0] src_y, dst_y;
  logic [X_W-1:0] src_x, dst_x;

  // bottom-up walk keeps a downward overlapping copy from reading rows it already wrote
  assign rev_d   = copy_i && (dy_i > by_i);
  assign row_end = (col_q == w_i - X_W'(1));
  assign last_o  = row_end && (rows_done_q == h_i - Y_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q       <= '0;
      rows_done_q <= '0;
      col_q       <= '0;
      rev_q       <= 1'b0;
    end else if (start_i) begin
      rev_q       <= rev_d;
      row_q       <= rev_d ? h_i - Y_W'(1) : '0;
      rows_done_q <= '0;
      col_q       <= '0;
    end else if (step_i) begin
      if (row_end) begin
        col_q       <= '0;
        rows_done_q <= rows_done_q + Y_W'(1);
        row_q       <= rev_q ? row_q - Y_W'(1) : row_q + Y_W'(1);
      end else begin
        col_q <= col_q + X_W'(1);
      end
    end
  end

  assign src_y      = by_i + row_q;
  assign src_x      = bx_i + col_q;
  assign dst_y      = dy_i + row_q;
  assign dst_x      = dx_i + col_q;
  assign src_addr_o = {src_y, src_x};
  assign dst_addr_o = {dst_y, dst_x};
endmodule

// File: rtl/rbe_regs.sv
module rbe_regs
  import rbe_pkg::*;
#(
  parameter int X_W    = 11,
  parameter int Y_W    = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              launch_o,
  output logic              copy_o,
  output logic [Y_W-1:0]    by_o,
  output logic [X_W-1:0]    bx_o,
  output logic [Y_W-1:0]    dy_o,
  output logic [X_W-1:0]    dx_o,
  output logic [Y_W-1:0]    h_o,
  output logic [X_W-1:0]    w_o,
  output logic [DATA_W-1:0] fg_o,
  output logic [7:0]        rop_o,
  output logic [DATA_W-1:0] pmask_o
);
  logic [7:0] op_q;
  logic       wr_ok;
  logic       op_ok;

  assign wr_ok    = we_i && !busy_i;
  assign op_ok    = (op_q == OP_FILL) || (op_q == OP_SCROLL);
  assign copy_o   = (op_q == OP_SCROLL);
  assign launch_o = wr_ok && (addr_i == RA_WIDTH) && op_ok &&
                    (h_o != '0) && (wdata_i[X_W-1:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      by_o    <= '0;
      bx_o    <= '0;
      dy_o    <= '0;
      dx_o    <= '0;
      h_o     <= '0;
      w_o     <= '0;
      fg_o    <= '0;
      rop_o   <= ROP_NEW;
      pmask_o <= '1;
    end else if (wr_ok) begin
      unique case (addr_i)
        RA_OP:     op_q    <= wdata_i[7:0];
        RA_SRC_Y:  by_o    <= wdata_i[Y_W-1:0];
        RA_SRC_X:  bx_o    <= wdata_i[X_W-1:0];
        RA_DST_Y:  dy_o    <= wdata_i[Y_W-1:0];
        RA_DST_X:  dx_o    <= wdata_i[X_W-1:0];
        RA_HEIGHT: h_o     <= wdata_i[Y_W-1:0];
        RA_WIDTH:  w_o     <= wdata_i[X_W-1:0];
        RA_FG:     fg_o    <= wdata_i;
        RA_ROP:    rop_o   <= wdata_i[7:0];
        RA_PMASK:  pmask_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rbe_box_engine.sv
module rbe_box_engine
  import rbe_pkg::*;
#(
  parameter int X_W    = 11,
  parameter int Y_W    = 11,
  parameter int DATA_W = 32,
  localparam int ADDR_W = X_W + Y_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  eng_state_e state_q, state_d;

  logic              launch, copy_mode, last_pix, step;
  logic [Y_W-1:0]    by_w, dy_w, h_w;
  logic [X_W-1:0]    bx_w, dx_w, w_w;
  logic [DATA_W-1:0] fg_w, pmask_w, src_q, new_pix;
  logic [7:0]        rop_w;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  rbe_regs #(.X_W(X_W), .Y_W(Y_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy_o),
    .launch_o(launch),
    .copy_o  (copy_mode),
    .by_o    (by_w),
    .bx_o    (bx_w),
    .dy_o    (dy_w),
    .dx_o    (dx_w),
    .h_o     (h_w),
    .w_o     (w_w),
    .fg_o    (fg_w),
    .rop_o   (rop_w),
    .pmask_o (pmask_w)
  );

  rbe_walker #(.X_W(X_W), .Y_W(Y_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch),
    .step_i    (step),
    .copy_i    (copy_mode),
    .by_i      (by_w),
    .bx_i      (bx_w),
    .dy_i      (dy_w),
    .dx_i      (dx_w),
    .h_i       (h_w),
    .w_i       (w_w),
    .src_addr_o(src_addr),
    .dst_addr_o(dst_addr),
    .last_o    (last_pix)
  );

  rbe_pixel_alu #(.DATA_W(DATA_W)) u_alu (
    .new_i  (new_pix),
    .old_i  (mem_rdata_i),
    .rop_i  (rop_w),
    .pmask_i(pmask_w),
    .pix_o  (mem_wdata_o)
  );

  assign step    = (state_q == ST_WRITE);
  assign new_pix = copy_mode ? src_q : fg_w;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (launch) state_d = copy_mode ? ST_RD_SRC : ST_RD_DST;
      ST_RD_SRC: state_d = ST_RD_DST;
      ST_RD_DST: state_d = ST_WRITE;
      ST_WRITE:  state_d = last_pix ? ST_IDLE : (copy_mode ? ST_RD_SRC : ST_RD_DST);
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      // source pixel lands on mem_rdata_i while the destination read is issued
      if (state_q == ST_RD_DST) src_q <= mem_rdata_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_addr_o = (state_q == ST_RD_SRC) ? src_addr : dst_addr;
endmodule

// File: rtl/rbe_checker.sv
module rbe_checker #(
  parameter int X_W    = 11,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [X_W-1:0]    reg_width_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] pmask_i
);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r10_fall_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_req_o && mem_we_o));

  a_r6_mask_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (((mem_wdata_o ^ mem_rdata_i) & ~pmask_i) == '0));

  a_r8_zero_width_no_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !busy_o && reg_addr_i == 4'd6 && reg_width_i == '0) |=> !busy_o);

  a_r11_no_back_to_back_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !(mem_req_o && mem_we_o));

  a_r10_we_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
endmodule

bind rbe_box_engine rbe_checker #(.X_W(X_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_width_i(reg_wdata_i[X_W-1:0]),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i),
  .pmask_i    (pmask_w)
);

// File: tb/tb_rbe_box_engine.sv
module tb_rbe_box_engine;
  localparam int X_W = 11;
  localparam int Y_W = 11;
  localparam int AW  = X_W + Y_W;
  localparam int XM  = (1 << X_W) - 1;
  localparam int YM  = (1 << Y_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  int idle_req = 0;
  int cyc = 0;

  logic [31:0] ram   [int];
  logic [31:0] model [int];

  always #2 clk = ~clk;

  rbe_box_engine #(.X_W(X_W), .Y_W(Y_W), .DATA_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] init_pix(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  function automatic logic [31:0] ram_get(int a);
    if (ram.exists(a)) return ram[a];
    return init_pix(a);
  endfunction

  function automatic logic [31:0] model_get(int a);
    if (model.exists(a)) return model[a];
    return init_pix(a);
  endfunction

  function automatic int pa(int y, int x);
    return ((y & YM) << X_W) | (x & XM);
  endfunction

  // synchronous frame memory: read data registered, held until next read
  always @(posedge clk) begin
    if (mem_req) begin
      n_req++;
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= ram_get(int'(mem_addr));
    end
    if (mem_req && !busy) idle_req++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic model_op(logic [7:0] op, int by, int bx, int dy, int dx, int h, int w,
                          logic [31:0] fg, logic [7:0] rop, logic [31:0] pm);
    bit rev;
    if (!((op == 8'h08) || (op == 8'h0B)) || h == 0 || w == 0) return;
    rev = (op == 8'h0B) && (dy > by);
    for (int i = 0; i < h; i++) begin
      int r = rev ? h - 1 - i : i;
      for (int c = 0; c < w; c++) begin
        logic [31:0] s, o, n;
        s = (op == 8'h0B) ? model_get(pa(by + r, bx + c)) : fg;
        o = model_get(pa(dy + r, dx + c));
        n = (rop == 8'h85) ? o : (rop == 8'h86) ? (s ^ o) : s;
        model[pa(dy + r, dx + c)] = (n & pm) | (o & ~pm);
      end
    end
  endtask

  task automatic check_mem(string req);
    int bad = 0;
    logic [31:0] act = '0, exp = '0;
    foreach (ram[k]) if (ram[k] !== model_get(k)) begin
      if (bad == 0) begin act = ram[k]; exp = model_get(k); end
      bad++;
    end
    foreach (model[k]) if (model[k] !== ram_get(k)) begin
      if (bad == 0) begin act = ram_get(k); exp = model[k]; end
      bad++;
    end
    check(bad == 0, req, "frame contents", act, exp);
  endtask

  // full: program every register; mid: register writes during busy (must be ignored)
  task automatic run_op(string req, bit full, bit mid, logic [7:0] op, int by, int bx,
                        int dy, int dx, int h, int w,
                        logic [31:0] fg, logic [7:0] rop, logic [31:0] pm);
    int cnt = 0;
    int req0;
    int exp_cyc;
    wr_reg(4'd0, 32'(op));
    wr_reg(4'd1, 32'(by));
    wr_reg(4'd2, 32'(bx));
    wr_reg(4'd3, 32'(dy));
    wr_reg(4'd4, 32'(dx));
    wr_reg(4'd5, 32'(h));
    if (full) begin
      wr_reg(4'd7, fg);
      wr_reg(4'd8, 32'(rop));
      wr_reg(4'd9, pm);
    end
    req0 = n_req;
    wr_reg(4'd6, 32'(w));
    if (mid) begin
      wr_reg(4'd7, ~fg);  cnt++;
      wr_reg(4'd6, 32'd1); cnt++;
    end
    while (busy && cnt < 100000) begin
      cnt++;
      @(negedge clk);
    end
    exp_cyc = (((op == 8'h08) || (op == 8'h0B)) && h != 0 && w != 0) ?
              ((op == 8'h0B) ? 3 : 2) * h * w : 0;
    model_op(op, by, bx, dy, dx, h, w, fg, rop, pm);
    check(cnt == exp_cyc, req, "busy cycles (R11)", 32'(cnt), 32'(exp_cyc));
    check((n_req - req0) == exp_cyc, req, "memory requests", 32'(n_req - req0), 32'(exp_cyc));
    check_mem(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
    check(mem_req == 1'b0, "R1", "req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);

    // R1 R5 R6: reset defaults of rop (new) and mask (all ones), fg zero
    run_op("R1", 1'b0, 1'b0, 8'h08, 0, 0, 2, 3, 2, 3, 32'h0, 8'h83, 32'hFFFF_FFFF);
    // R3: plain fill, colour with red/green/blue lanes
    run_op("R3", 1'b1, 1'b0, 8'h08, 0, 0, 5, 10, 3, 4, 32'h0033_2211, 8'h83, 32'hFFFF_FFFF);
    // R3: column wrap at 2047
    run_op("R3", 1'b1, 1'b0, 8'h08, 0, 0, 7, 2045, 2, 5, 32'hABCD_0001, 8'h83, 32'hFFFF_FFFF);
    // R5: old and xor and unknown code
    run_op("R5", 1'b1, 1'b0, 8'h08, 0, 0, 9, 1, 2, 2, 32'h1234_5678, 8'h85, 32'hFFFF_FFFF);
    run_op("R5", 1'b1, 1'b0, 8'h08, 0, 0, 9, 1, 2, 2, 32'hF0F0_F0F0, 8'h86, 32'hFFFF_FFFF);
    run_op("R5", 1'b1, 1'b0, 8'h08, 0, 0, 9, 4, 1, 3, 32'h5555_AAAA, 8'h11, 32'hFFFF_FFFF);
    // R6: partial plane mask
    run_op("R6", 1'b1, 1'b0, 8'h08, 0, 0, 12, 0, 2, 3, 32'hFFFF_FFFF, 8'h83, 32'h00FF_00F0);
    // R4: non-overlapping copy
    run_op("R4", 1'b1, 1'b0, 8'h0B, 20, 30, 24, 30, 3, 4, 32'h0, 8'h83, 32'hFFFF_FFFF);
    // R7: overlapping copy downward and upward
    run_op("R7", 1'b1, 1'b0, 8'h0B, 30, 5, 31, 5, 4, 3, 32'h0, 8'h83, 32'hFFFF_FFFF);
    run_op("R7", 1'b1, 1'b0, 8'h0B, 40, 5, 38, 5, 4, 3, 32'h0, 8'h83, 32'hFFFF_FFFF);
    // R8: zero height, zero width
    run_op("R8", 1'b1, 1'b0, 8'h08, 0, 0, 50, 0, 0, 4, 32'h1, 8'h83, 32'hFFFF_FFFF);
    run_op("R8", 1'b1, 1'b0, 8'h0B, 1, 1, 50, 0, 3, 0, 32'h1, 8'h83, 32'hFFFF_FFFF);
    // R2: unknown opcode
    run_op("R2", 1'b1, 1'b0, 8'h05, 0, 0, 52, 0, 3, 3, 32'h1, 8'h83, 32'hFFFF_FFFF);
    // R9: writes while busy ignored
    run_op("R9", 1'b1, 1'b1, 8'h08, 0, 0, 55, 0, 3, 4, 32'h00DE_AD00, 8'h83, 32'hFFFF_FFFF);

    // R3 R4 R5 R6 R7: random mix
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] op = (sel == 0) ? 8'h05 : (sel < 5) ? 8'h08 : 8'h0B;
      int by = $urandom_range(0, 20);
      int bx = ($urandom_range(0, 3) == 0) ? 2044 + $urandom_range(0, 3) : $urandom_range(0, 12);
      int dy = $urandom_range(0, 24);
      int dx = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 12) : bx;
      int h  = $urandom_range(0, 5);
      int w  = $urandom_range(0, 5);
      int rs = $urandom_range(0, 3);
      logic [7:0] rop = (rs == 0) ? 8'h83 : (rs == 1) ? 8'h85 : (rs == 2) ? 8'h86 : 8'($urandom);
      logic [31:0] pm = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
      run_op("R4", 1'b1, 1'b0, op, by, bx, dy, dx, h, w, $urandom, rop, pm);
    end

    // R10: no request ever issued while idle
    check(idle_req == 0, "R10", "requests while idle", 32'(idle_req), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule